// File: doc/BRIEF.md
# Dual-Issue Grouping Estimator

This block watches a stream of retired instructions, at most one per clock, and estimates how many issue groups (supercycles) the same stream would need on a narrow two-wide machine. Each instruction arrives with a functional-unit class code and a flag that marks a dependency on the instruction before it. The block keeps a small issue budget for every class and one overall budget for the group. When the instruction cannot join the current group, it opens a new one.

Four saturating counters are driven on output ports: supercycles, group breaks caused by dependencies, loads and stores. A synchronous clear input returns the block to its start state, the same state the reset gives. The block does no dispatch or execution. It only does the accounting for the grouping.

Top module: `gim_issue_meter`

## Requirements
- R1: Class codes are 4 bits. Code 2 (compare), code 3 (branch) and code 4 (jump) reload to a budget of 1. Every other code from 0 to 15 reloads to a budget of 2. Code 10 is a store and code 11 is a load.
- R2: A valid instruction opens a new group when its own class budget is 0, when its dependency flag is set, or when the overall group budget is 0.
- R3: Opening a group adds one to the supercycle counter, reloads every class budget to its R1 value and reloads the overall budget to 2.
- R4: The dependency-break counter adds one only for a valid instruction whose dependency flag is set. Such an instruction always opens a group, so this count never exceeds the supercycle count.
- R5: The group decision uses the budgets as they were before the instruction arrived. After the decision, the instruction's class budget and the overall budget each drop by one. For example, three arith instructions (code 9) after a clear give two supercycles.
- R6: Each valid store adds one to the store counter and each valid load adds one to the load counter. No other class changes either counter.
- R7: After reset or clear, all counters read 0, every class budget is 0 and the overall budget is 4, so the first valid instruction always opens a group.
- R8: Every counter holds at its maximum value instead of wrapping.
- R9: A cycle with the valid input low changes no counter and no budget, whatever the class and dependency inputs carry.
- R10: The counters are registered. The effect of an instruction shows on the outputs one clock after the instruction is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear of counters and budgets |
| in_valid | input | 1 | A retired instruction is presented this cycle |
| in_cls | input | CLS_W | Functional-unit class code |
| in_dep | input | 1 | Instruction depends on the previous one |
| supercycles | output | CNT_W | Issue groups opened |
| dep_breaks | output | CNT_W | Groups opened with the dependency flag set |
| loads | output | CNT_W | Load instructions seen |
| stores | output | CNT_W | Store instructions seen |

## Verification
The bench targets the one-slot classes: two compares in a row must give two groups. A design that reloaded them to 2 would merge the pair into one group. It checks that the overall budget closes a group after two mixed instructions even when both class budgets still have room. A design that used post-decrement budgets, or that ignored the overall budget, would show supercycle counts that are off by one. A dependency flag on the first instruction after a clear must count as a dependency break, so the bench checks that case too. A design that added the break count only when a group was not already due would miss it. Narrowed counters driven past their maximum must stop at all-ones and not wrap to zero. Cycles with valid low that carry random class and dependency inputs must leave every output unchanged.

// File: rtl/gim_pkg.sv
package gim_pkg;

    // Class codes that the accounting itself depends on
    localparam int unsigned FU_CMP    = 2;
    localparam int unsigned FU_BRANCH = 3;
    localparam int unsigned FU_JUMP   = 4;
    localparam int unsigned FU_STORE  = 10;
    localparam int unsigned FU_LOAD   = 11;

    // Decoded view of one presented instruction
    typedef struct packed {
        logic valid;
        logic dep;
        logic is_load;
        logic is_store;
    } instr_ev_t;

    // Classes that may issue only once per group
    function automatic bit is_single_slot(input int unsigned code);
        return (code == FU_CMP) || (code == FU_BRANCH) || (code == FU_JUMP);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/gim_sat_counter.sv
module gim_sat_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != TOP)) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/gim_class_budget.sv
module gim_class_budget #(
    parameter int unsigned CLS_W  = 4,
    parameter int unsigned BUD_W  = 2,
    parameter int unsigned WIDE   = 2,
    parameter int unsigned NARROW = 1
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             adv,
    input  logic             grp_open,
    input  logic [CLS_W-1:0] cls,
    output logic [BUD_W-1:0] cur_bud
);
    import gim_pkg::*;

    localparam int unsigned NCLS = 1 << CLS_W;
    localparam logic [BUD_W-1:0] ONE = BUD_W'(1);

    logic [NCLS-1:0][BUD_W-1:0] bud_vec;

    for (genvar g = 0; g < NCLS; g++) begin : g_slot
        localparam logic [BUD_W-1:0] RELOAD =
            is_single_slot(g) ? BUD_W'(NARROW) : BUD_W'(WIDE);
        logic [BUD_W-1:0] q;
        logic             hit;

        assign hit = (cls == CLS_W'(g));

        always_ff @(posedge clk) begin
            if (clr) begin
                q <= '0;
            end else if (adv) begin
                if (grp_open) begin
                    q <= hit ? (RELOAD - ONE) : RELOAD;
                end else if (hit) begin
                    q <= q - ONE;
                end
            end
        end

        assign bud_vec[g] = q;
    end

    assign cur_bud = bud_vec[cls];
endmodule

// File: rtl/gim_group_ctrl.sv
module gim_group_ctrl #(
    parameter int unsigned BUD_W = 2,
    parameter int unsigned TOT_W = 3,
    parameter int unsigned GROUP = 2,
    parameter int unsigned INIT  = 4
) (
    input  logic             clk,
    input  logic             clr,
    input  gim_pkg::instr_ev_t ev,
    input  logic [BUD_W-1:0] cls_bud,
    output logic             grp_open,
    output logic             dep_break
);
    localparam logic [TOT_W-1:0] ONE = TOT_W'(1);

    logic [TOT_W-1:0] tot_q;
    logic             cls_empty;
    logic             tot_empty;

    assign cls_empty = (cls_bud == '0);
    assign tot_empty = (tot_q == '0);
    assign grp_open  = ev.valid && (cls_empty || ev.dep || tot_empty);
    assign dep_break = ev.valid && ev.dep;

    always_ff @(posedge clk) begin
        if (clr) begin
            tot_q <= TOT_W'(INIT);
        end else if (ev.valid) begin
            tot_q <= grp_open ? (TOT_W'(GROUP) - ONE) : (tot_q - ONE);
        end
    end
endmodule

// File: rtl/gim_issue_meter.sv
module gim_issue_meter #(
    parameter int unsigned CLS_W  = 4,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned WIDE   = 2,
    parameter int unsigned NARROW = 1,
    parameter int unsigned GROUP  = 2,
    parameter int unsigned INIT   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             in_valid,
    input  logic [CLS_W-1:0] in_cls,
    input  logic             in_dep,
    output logic [CNT_W-1:0] supercycles,
    output logic [CNT_W-1:0] dep_breaks,
    output logic [CNT_W-1:0] loads,
    output logic [CNT_W-1:0] stores
);
    import gim_pkg::*;

    localparam int unsigned BUD_W = $clog2(max2(WIDE, NARROW) + 1);
    localparam int unsigned TOT_W = $clog2(max2(GROUP, INIT) + 1);

    logic             wipe;
    instr_ev_t        ev;
    logic [BUD_W-1:0] cls_bud;
    logic             grp_open;
    logic             dep_break;

    assign wipe        = rst || clr;
    assign ev.valid    = in_valid;
    assign ev.dep      = in_dep;
    assign ev.is_load  = in_valid && (in_cls == CLS_W'(FU_LOAD));
    assign ev.is_store = in_valid && (in_cls == CLS_W'(FU_STORE));

    gim_class_budget #(
        .CLS_W(CLS_W), .BUD_W(BUD_W), .WIDE(WIDE), .NARROW(NARROW)
    ) u_budget (
        .clk(clk), .clr(wipe), .adv(ev.valid), .grp_open(grp_open),
        .cls(in_cls), .cur_bud(cls_bud)
    );

    gim_group_ctrl #(
        .BUD_W(BUD_W), .TOT_W(TOT_W), .GROUP(GROUP), .INIT(INIT)
    ) u_ctrl (
        .clk(clk), .clr(wipe), .ev(ev), .cls_bud(cls_bud),
        .grp_open(grp_open), .dep_break(dep_break)
    );

    gim_sat_counter #(.W(CNT_W)) u_cnt_super (
        .clk(clk), .clr(wipe), .inc(grp_open), .cnt(supercycles));
    gim_sat_counter #(.W(CNT_W)) u_cnt_dep (
        .clk(clk), .clr(wipe), .inc(dep_break), .cnt(dep_breaks));
    gim_sat_counter #(.W(CNT_W)) u_cnt_load (
        .clk(clk), .clr(wipe), .inc(ev.is_load), .cnt(loads));
    gim_sat_counter #(.W(CNT_W)) u_cnt_store (
        .clk(clk), .clr(wipe), .inc(ev.is_store), .cnt(stores));
endmodule

// File: rtl/gim_issue_meter_chk.sv
module gim_issue_meter_chk #(
    parameter int unsigned CLS_W = 4,
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             in_valid,
    input logic [CLS_W-1:0] in_cls,
    input logic             in_dep,
    input logic [CNT_W-1:0] supercycles,
    input logic [CNT_W-1:0] dep_breaks,
    input logic [CNT_W-1:0] loads,
    input logic [CNT_W-1:0] stores
);
    localparam logic [CNT_W-1:0] TOP = '1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CLS_W-1:0] C_LOAD  = CLS_W'(11);
    localparam logic [CLS_W-1:0] C_STORE = CLS_W'(10);

    // Set from clear until the first valid instruction
    logic fresh;
    always_ff @(posedge clk) begin
        if (rst || clr) fresh <= 1'b1;
        else if (in_valid) fresh <= 1'b0;
    end

    // R7
    a_r7_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
        clr |=> (supercycles == '0 && dep_breaks == '0 && loads == '0 && stores == '0));

    // R7
    a_r7_first_opens: assert property (@(posedge clk) disable iff (rst)
        (fresh && in_valid && !clr) |=> supercycles == $past(supercycles) + ONE);

    // R2
    a_r2_dep_opens: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_dep && !clr && supercycles != TOP)
        |=> supercycles == $past(supercycles) + ONE);

    // R4
    a_r4_dep_count: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_dep && !clr && dep_breaks != TOP)
        |=> dep_breaks == $past(dep_breaks) + ONE);

    // R4
    a_r4_dep_bounded: assert property (@(posedge clk) disable iff (rst)
        dep_breaks <= supercycles);

    // R6
    a_r6_load_count: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_cls == C_LOAD && !clr && loads != TOP)
        |=> loads == $past(loads) + ONE);

    // R6
    a_r6_store_count: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_cls == C_STORE && !clr && stores != TOP)
        |=> stores == $past(stores) + ONE);

    // R9
    a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !clr)
        |=> ($stable(supercycles) && $stable(dep_breaks) && $stable(loads) && $stable(stores)));

    // R8
    a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
        (supercycles == TOP && !clr) |=> supercycles == TOP);

    // R3
    a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (supercycles == $past(supercycles) || supercycles == $past(supercycles) + ONE));
endmodule

bind gim_issue_meter gim_issue_meter_chk #(.CLS_W(CLS_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_gim_issue_meter.sv
`timescale 1ns/1ps
module tb_gim_issue_meter;
    localparam int CLS_W = 4;
    localparam int CNT_W = 6;
    localparam int TOPV  = (1 << CNT_W) - 1;

    logic clk = 0;
    logic rst = 1;
    logic clr = 0;
    logic in_valid = 0;
    logic [CLS_W-1:0] in_cls = '0;
    logic in_dep = 0;
    logic [CNT_W-1:0] supercycles, dep_breaks, loads, stores;

    gim_issue_meter #(.CLS_W(CLS_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .in_cls(in_cls),
        .in_dep(in_dep), .supercycles(supercycles), .dep_breaks(dep_breaks),
        .loads(loads), .stores(stores));

    always #10 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    // Reference model state
    int m_bud[16];
    int m_tot, m_sc, m_dc, m_lc, m_stc;

    function automatic int reload_val(int c);
        return (c == 2 || c == 3 || c == 4) ? 1 : 2;
    endfunction

    function automatic int bump(int v);
        return (v < TOPV) ? v + 1 : v;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 16; i++) m_bud[i] = 0;
        m_tot = 4; m_sc = 0; m_dc = 0; m_lc = 0; m_stc = 0;
    endtask

    task automatic model_step(bit v, int c, bit d, bit cl);
        bit opn;
        if (cl) begin
            model_clear();
        end else if (v) begin
            opn = (m_bud[c] < 1) || d || (m_tot < 1);
            if (opn) begin
                m_sc = bump(m_sc);
                if (d) m_dc = bump(m_dc);
                for (int i = 0; i < 16; i++) m_bud[i] = reload_val(i);
                m_tot = 2;
            end
            m_bud[c] = m_bud[c] - 1;
            m_tot = m_tot - 1;
            if (c == 11) m_lc = bump(m_lc);
            if (c == 10) m_stc = bump(m_stc);
        end
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic compare_model();
        check("R3 supercycles vs model", supercycles, m_sc);
        check("R4 dep_breaks vs model", dep_breaks, m_dc);
        check("R6 loads vs model", loads, m_lc);
        check("R6 stores vs model", stores, m_stc);
    endtask

    // One clock: compare away from the edge, then present new inputs
    task automatic tick(bit v, int c, bit d, bit cl);
        @(posedge clk);
        #5;
        compare_model();
        model_step(v, c, d, cl);
        in_valid = v; in_cls = CLS_W'(c); in_dep = d; clr = cl;
    endtask

    task automatic idle();
        tick(0, $urandom_range(0, 15), $urandom_range(0, 1), 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        #5;
        rst = 0;
        // R7 reset state
        check("R7 reset supercycles", supercycles, 0);
        check("R7 reset loads", loads, 0);

        // R5: three arith after clear -> two groups
        tick(1, 9, 0, 1);
        tick(1, 9, 0, 0); tick(1, 9, 0, 0); tick(1, 9, 0, 0);
        idle();
        check("R5 three arith groups", supercycles, 2);
        // R10: registered output, first instruction seen one clock later
        tick(1, 0, 0, 1);
        tick(1, 10, 0, 0);
        check("R10 no change same cycle", stores, 0);
        idle();
        check("R10 store visible next cycle", stores, 1);

        // R1: two compares need two groups
        tick(1, 0, 0, 1);
        tick(1, 2, 0, 0); tick(1, 2, 0, 0);
        idle();
        check("R1 compare pair", supercycles, 2);

        // R2: overall budget closes a group after two mixed instructions
        tick(1, 0, 0, 1);
        tick(1, 1, 0, 0); tick(1, 7, 0, 0);
        idle();
        check("R2 two mixed fit one group", supercycles, 1);
        tick(1, 6, 0, 0);
        idle();
        check("R2 overall budget forces group", supercycles, 2);

        // R1: unused code 13 reloads to 2
        tick(1, 0, 0, 1);
        tick(1, 13, 0, 0); tick(1, 13, 0, 0); tick(1, 13, 0, 0);
        idle();
        check("R1 unused code budget two", supercycles, 2);

        // R4: dependency on first instruction counts
        tick(1, 0, 0, 1);
        tick(1, 9, 1, 0);
        idle();
        check("R4 dep on first instr", dep_breaks, 1);
        tick(1, 9, 1, 0);
        idle();
        check("R4 dep forces group", supercycles, 2);
        check("R4 dep count", dep_breaks, 2);

        // R9: idle cycles with junk inputs
        for (int i = 0; i < 20; i++) idle();
        check("R9 idle holds supercycles", supercycles, 2);
        check("R9 idle holds dep_breaks", dep_breaks, 2);
        check("R6 no loads from other classes", loads, 0);

        // R8: saturation
        tick(1, 0, 0, 1);
        for (int i = 0; i < 70; i++) tick(1, 11, 0, 0);
        idle();
        check("R8 loads saturate", loads, TOPV);
        for (int i = 0; i < 70; i++) tick(1, 10, 1, 0);
        idle();
        check("R8 supercycles saturate", supercycles, TOPV);
        check("R8 dep_breaks saturate", dep_breaks, TOPV);
        check("R8 stores saturate", stores, TOPV);
        check("R8 loads still held", loads, TOPV);

        // Random stream checked against the model every clock
        tick(1, 0, 0, 1);
        for (int i = 0; i < 4000; i++) begin
            tick($urandom_range(0, 3) != 0, $urandom_range(0, 15),
                 $urandom_range(0, 7) == 0, $urandom_range(0, 299) == 0);
        end
        idle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule